// File: doc/BRIEF.md
# Transmit Abort Status Tracker

This block follows a single frame transmission from the moment the host requests it until it ends, and decides whether the frame finished cleanly, was withdrawn by the host, or has to be given up. It takes its information from the MAC, which reports collisions together with the number of bytes already sent, a carrier-busy indication and a normal end of frame. The host provides the retry limit, the largest permitted frame length, a permission for oversize frames, a wait-forever option and the duplex mode.

When any abort cause appears, the transmit request drops. A sticky abort flag sets, and a transmit-error event and a transmit-done event pulse together. The block never retries the frame on its own. A collision that comes too late also sets a sticky late-collision flag. Both sticky flags stay set until the host writes to clear them. Every end of transmission pulses the done event, and a clean finish also pulses a success event. At each start the block presents the address one past the end of the frame in buffer memory, which is where the status vector goes. In full duplex there is no shared medium, so the oversize check is the only cause that can abort a frame.

Top module: `txAbortTracker`

## Requirements
- R1: After reset, txRequest, abortSticky, lateColSticky, txErrEvt, txDoneEvt and txOkEvt are 0 and statusAddr is 0.
- R2: A txStart seen while no transmission is active raises txRequest on the next cycle and loads statusAddr with frameEnd + 1, taken modulo 2^ADDR_W. A txStart seen while a transmission is active changes nothing.
- R3: A frame started with frameLen greater than maxFrameLen while hugeEnable is 0 aborts on the second clock edge after txStart, in either duplex mode. A length equal to maxFrameLen does not abort, and neither does any length when hugeEnable is 1.
- R4: In half duplex, the collision that brings the collision count of the current frame to retryMax + 1 aborts the frame. Up to retryMax collisions do not abort it.
- R5: In half duplex, a collision while bytesSent is 64 or more aborts the frame and sets lateColSticky. At 63 bytes it counts as an ordinary collision.
- R6: In half duplex with deferForever at 0, mediumBusy held for DEFER_CYCLES consecutive active cycles aborts the frame, where DEFER_CYCLES = floor(CLK_HZ x 2.4287 ms). The count restarts whenever mediumBusy drops. With deferForever at 1 the frame never aborts for this reason.
- R7: In full duplex (fullDuplex = 1), collisions and mediumBusy never abort a frame.
- R8: An abort clears txRequest, sets abortSticky, and pulses txErrEvt and txDoneEvt together for one cycle. txRequest then stays 0 until the next txStart.
- R9: hostCancel during an active transmission clears txRequest and pulses txDoneEvt, with neither txErrEvt nor txOkEvt.
- R10: txEndOk during an active transmission clears txRequest and pulses txDoneEvt. It pulses txOkEvt only when abortSticky is 0 at that moment.
- R11: abortSticky and lateColSticky are unaffected by new starts or later ends. They clear only on clrAbort or clrLateCol respectively, and a set on the same edge takes precedence over the clear.
- R12: When an abort cause coincides with hostCancel or txEndOk, the abort is reported and txOkEvt stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txStart | input | 1 | Host request to begin transmitting a frame |
| hostCancel | input | 1 | Host withdraws the active request |
| txEndOk | input | 1 | MAC reports the frame finished normally |
| collision | input | 1 | MAC reports a collision this cycle |
| bytesSent | input | BYTE_W | Bytes already sent in the current frame |
| mediumBusy | input | 1 | Carrier sensed, transmission deferred |
| fullDuplex | input | 1 | 1 = full duplex, 0 = half duplex |
| retryMax | input | RETRY_W | Collisions tolerated before giving up |
| deferForever | input | 1 | 1 = never abort on deferral |
| hugeEnable | input | 1 | 1 = permit frames above maxFrameLen |
| maxFrameLen | input | LEN_W | Largest permitted frame length |
| frameLen | input | LEN_W | Length of the frame being started |
| frameEnd | input | ADDR_W | Buffer address of the last frame byte |
| clrAbort | input | 1 | Host write clearing abortSticky |
| clrLateCol | input | 1 | Host write clearing lateColSticky |
| txRequest | output | 1 | Transmission in progress |
| abortSticky | output | 1 | Sticky transmit-abort status |
| lateColSticky | output | 1 | Sticky late-collision status |
| txErrEvt | output | 1 | One-cycle transmit-error event |
| txDoneEvt | output | 1 | One-cycle end-of-transmission event |
| txOkEvt | output | 1 | One-cycle successful-completion event |
| statusAddr | output | ADDR_W | Status vector address, frame end + 1 |

## Verification
The bench targets the exact threshold of each abort cause. The retry limit must allow its full count, which catches an off-by-one that gives up one collision early. The late-collision boundary sits between 63 and 64 bytes. The oversize comparison must be strict, so an inclusive compare would reject a legal maximum-length frame. The deferral timer must fire on exactly its computed cycle and restart when the medium goes idle, since a timer that only pauses would abort a frame after an interrupted wait. Beyond the thresholds, the bench confirms that full duplex ignores collisions and carrier. It checks that a leftover abort flag suppresses the success event, that a set beats a simultaneous clear, and that a start arriving mid-frame does not move the status address.

// File: rtl/txAbortPkg.sv
package txAbortPkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } txStateT;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic startLatch;
    logic abortSet;
    logic lateSet;
    logic doneEvt;
    logic errEvt;
    logic okEvt;
  } txStrobeT;

endpackage

// File: rtl/txAbortCtrl.sv
module txAbortCtrl
  import txAbortPkg::*;
#(
  parameter int CLK_HZ     = 25_000_000,
  parameter int RETRY_W    = 4,
  parameter int BYTE_W     = 16,
  parameter int LATE_BYTES = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txStart,
  input  logic               hostCancel,
  input  logic               txEndOk,
  input  logic               collision,
  input  logic [BYTE_W-1:0]  bytesSent,
  input  logic               mediumBusy,
  input  logic               fullDuplex,
  input  logic [RETRY_W-1:0] retryMax,
  input  logic               deferForever,
  input  logic               oversizeQ,
  input  logic               abortStickyQ,
  output logic               txRequest,
  output txStrobeT           strb
);

  // deferral limit of 2.4287 ms expressed in clock cycles
  localparam longint DEFER_CYCLES = ((longint'(CLK_HZ) / 1000) * 24287) / 10000;
  localparam int     DEFER_W      = $clog2(DEFER_CYCLES + 1);
  localparam logic [DEFER_W-1:0] DEFER_LAST = DEFER_W'(DEFER_CYCLES - 1);

  txStateT            state;
  logic [RETRY_W-1:0] collCnt;
  logic [DEFER_W-1:0] deferCnt;

  logic active, halfDup;
  logic lateHit, excessHit, deferHit;
  logic abortNow, cancelNow, endNow;

  always_comb begin
    active    = (state == ST_ACTIVE);
    halfDup   = !fullDuplex;
    lateHit   = collision && halfDup && (bytesSent >= BYTE_W'(LATE_BYTES));
    excessHit = collision && halfDup && (collCnt == retryMax);
    deferHit  = mediumBusy && halfDup && !deferForever && (deferCnt == DEFER_LAST);
    abortNow  = active && (oversizeQ || lateHit || excessHit || deferHit);
    cancelNow = active && !abortNow && hostCancel;
    endNow    = active && !abortNow && !hostCancel && txEndOk;

    strb.startLatch = !active && txStart;
    strb.abortSet   = abortNow;
    strb.lateSet    = abortNow && lateHit;
    strb.errEvt     = abortNow;
    strb.doneEvt    = abortNow || cancelNow || endNow;
    strb.okEvt      = endNow && !abortStickyQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else if (strb.startLatch) begin
      state <= ST_ACTIVE;
    end else if (strb.doneEvt) begin
      state <= ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.startLatch) begin
      collCnt <= '0;
    end else if (active && collision && halfDup && !abortNow) begin
      collCnt <= collCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.startLatch) begin
      deferCnt <= '0;
    end else if (active) begin
      if (!mediumBusy || !halfDup) begin
        deferCnt <= '0;
      end else if (deferCnt != DEFER_LAST) begin
        deferCnt <= deferCnt + 1'b1;
      end
    end
  end

  assign txRequest = active;

  // R2
  start_raises_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.startLatch |=> txRequest);

  // R8
  end_drops_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doneEvt |=> !txRequest);

  // R7
  full_duplex_only_oversize_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.errEvt && fullDuplex) |-> oversizeQ);

endmodule

// File: rtl/txAbortDatapath.sv
module txAbortDatapath
  import txAbortPkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobeT          strb,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [LEN_W-1:0]  maxFrameLen,
  input  logic              hugeEnable,
  input  logic [ADDR_W-1:0] frameEnd,
  input  logic              clrAbort,
  input  logic              clrLateCol,
  output logic              oversizeQ,
  output logic              abortSticky,
  output logic              lateColSticky,
  output logic [ADDR_W-1:0] statusAddr,
  output logic              txErrEvt,
  output logic              txDoneEvt,
  output logic              txOkEvt
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oversizeQ  <= 1'b0;
      statusAddr <= '0;
    end else if (strb.startLatch) begin
      oversizeQ  <= (frameLen > maxFrameLen) && !hugeEnable;
      statusAddr <= frameEnd + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      abortSticky <= 1'b0;
    end else if (strb.abortSet) begin
      abortSticky <= 1'b1;
    end else if (clrAbort) begin
      abortSticky <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lateColSticky <= 1'b0;
    end else if (strb.lateSet) begin
      lateColSticky <= 1'b1;
    end else if (clrLateCol) begin
      lateColSticky <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txErrEvt  <= 1'b0;
      txDoneEvt <= 1'b0;
      txOkEvt   <= 1'b0;
    end else begin
      txErrEvt  <= strb.errEvt;
      txDoneEvt <= strb.doneEvt;
      txOkEvt   <= strb.okEvt;
    end
  end

  // R8
  err_implies_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    txErrEvt |-> txDoneEvt);

  // R10
  ok_excludes_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    txOkEvt |-> !txErrEvt);

  // R5
  late_with_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lateColSticky) |-> (abortSticky && txErrEvt));

endmodule

// File: rtl/txAbortTracker.sv
module txAbortTracker
  import txAbortPkg::*;
#(
  parameter int CLK_HZ  = 25_000_000,
  parameter int RETRY_W = 4,
  parameter int BYTE_W  = 16,
  parameter int LEN_W   = 16,
  parameter int ADDR_W  = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txStart,
  input  logic               hostCancel,
  input  logic               txEndOk,
  input  logic               collision,
  input  logic [BYTE_W-1:0]  bytesSent,
  input  logic               mediumBusy,
  input  logic               fullDuplex,
  input  logic [RETRY_W-1:0] retryMax,
  input  logic               deferForever,
  input  logic               hugeEnable,
  input  logic [LEN_W-1:0]   maxFrameLen,
  input  logic [LEN_W-1:0]   frameLen,
  input  logic [ADDR_W-1:0]  frameEnd,
  input  logic               clrAbort,
  input  logic               clrLateCol,
  output logic               txRequest,
  output logic               abortSticky,
  output logic               lateColSticky,
  output logic               txErrEvt,
  output logic               txDoneEvt,
  output logic               txOkEvt,
  output logic [ADDR_W-1:0]  statusAddr
);

  txStrobeT strb;
  logic     oversizeQ;

  txAbortCtrl #(
    .CLK_HZ (CLK_HZ),
    .RETRY_W(RETRY_W),
    .BYTE_W (BYTE_W)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .txStart     (txStart),
    .hostCancel  (hostCancel),
    .txEndOk     (txEndOk),
    .collision   (collision),
    .bytesSent   (bytesSent),
    .mediumBusy  (mediumBusy),
    .fullDuplex  (fullDuplex),
    .retryMax    (retryMax),
    .deferForever(deferForever),
    .oversizeQ   (oversizeQ),
    .abortStickyQ(abortSticky),
    .txRequest   (txRequest),
    .strb        (strb)
  );

  txAbortDatapath #(
    .LEN_W (LEN_W),
    .ADDR_W(ADDR_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .frameLen     (frameLen),
    .maxFrameLen  (maxFrameLen),
    .hugeEnable   (hugeEnable),
    .frameEnd     (frameEnd),
    .clrAbort     (clrAbort),
    .clrLateCol   (clrLateCol),
    .oversizeQ    (oversizeQ),
    .abortSticky  (abortSticky),
    .lateColSticky(lateColSticky),
    .statusAddr   (statusAddr),
    .txErrEvt     (txErrEvt),
    .txDoneEvt    (txDoneEvt),
    .txOkEvt      (txOkEvt)
  );

endmodule

// File: tb/txAbortTracker_tb_top.sv
`timescale 1ns/1ps
module txAbortTracker_tb_top;

  localparam int TB_CLK_HZ = 1_000_000;
  // 1 MHz x 2.4287 ms = 2428.7 -> 2428 whole cycles
  localparam int DEFER_EXP = 2428;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txStart = 0, hostCancel = 0, txEndOk = 0, collision = 0;
  logic [15:0] bytesSent = 0;
  logic        mediumBusy = 0, fullDuplex = 0, deferForever = 0, hugeEnable = 0;
  logic [3:0]  retryMax = 4'd3;
  logic [15:0] maxFrameLen = 16'd1518, frameLen = 16'd100;
  logic [12:0] frameEnd = 13'd0;
  logic        clrAbort = 0, clrLateCol = 0;
  logic        txRequest, abortSticky, lateColSticky, txErrEvt, txDoneEvt, txOkEvt;
  logic [12:0] statusAddr;

  int checks = 0, errors = 0;
  int errCnt = 0, doneCnt = 0, okCnt = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  txAbortTracker #(.CLK_HZ(TB_CLK_HZ)) dut_i (
    .clk(clk), .rstN(rstN), .txStart(txStart), .hostCancel(hostCancel),
    .txEndOk(txEndOk), .collision(collision), .bytesSent(bytesSent),
    .mediumBusy(mediumBusy), .fullDuplex(fullDuplex), .retryMax(retryMax),
    .deferForever(deferForever), .hugeEnable(hugeEnable),
    .maxFrameLen(maxFrameLen), .frameLen(frameLen), .frameEnd(frameEnd),
    .clrAbort(clrAbort), .clrLateCol(clrLateCol), .txRequest(txRequest),
    .abortSticky(abortSticky), .lateColSticky(lateColSticky),
    .txErrEvt(txErrEvt), .txDoneEvt(txDoneEvt), .txOkEvt(txOkEvt),
    .statusAddr(statusAddr)
  );

  // event pulse counters, sampled mid-cycle
  always @(negedge clk) begin
    if (rstN) begin
      errCnt  <= errCnt + int'(txErrEvt);
      doneCnt <= doneCnt + int'(txDoneEvt);
      okCnt   <= okCnt + int'(txOkEvt);
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearSticky();
    clrAbort = 1; clrLateCol = 1;
    step();
    clrAbort = 0; clrLateCol = 0;
  endtask

  task automatic startFrame(input logic [15:0] len, input logic [12:0] endA);
    frameLen = len; frameEnd = endA; txStart = 1;
    step();
    txStart = 0;
  endtask

  typedef struct packed {
    logic        fd;
    logic [15:0] len;
    logic        huge;
    logic [3:0]  coll;
    logic [15:0] bytes;
    logic        expAbort;
    logic        expLate;
  } vecT;

  localparam vecT VECS [10] = '{
    '{1'b0, 16'd100,  1'b0, 4'd0, 16'd10,  1'b0, 1'b0}, // R10 plain success
    '{1'b0, 16'd1519, 1'b0, 4'd0, 16'd10,  1'b1, 1'b0}, // R3 oversize half
    '{1'b0, 16'd1519, 1'b1, 4'd0, 16'd10,  1'b0, 1'b0}, // R3 huge permitted
    '{1'b1, 16'd1519, 1'b0, 4'd0, 16'd10,  1'b1, 1'b0}, // R3 oversize full
    '{1'b0, 16'd1518, 1'b0, 4'd0, 16'd10,  1'b0, 1'b0}, // R3 equal length
    '{1'b0, 16'd100,  1'b0, 4'd3, 16'd10,  1'b0, 1'b0}, // R4 retryMax collisions
    '{1'b0, 16'd100,  1'b0, 4'd4, 16'd10,  1'b1, 1'b0}, // R4 one too many
    '{1'b0, 16'd100,  1'b0, 4'd1, 16'd64,  1'b1, 1'b1}, // R5 late at 64
    '{1'b0, 16'd100,  1'b0, 4'd1, 16'd63,  1'b0, 1'b0}, // R5 ordinary at 63
    '{1'b1, 16'd100,  1'b0, 4'd5, 16'd64,  1'b0, 1'b0}  // R7 full ignores collisions
  };

  initial begin
    int e0, d0, o0, applied;

    // R1 reset state
    repeat (3) step();
    chk("R1 txRequest", int'(txRequest), 0);
    chk("R1 abortSticky", int'(abortSticky), 0);
    chk("R1 lateColSticky", int'(lateColSticky), 0);
    chk("R1 events", int'({txErrEvt, txDoneEvt, txOkEvt}), 0);
    chk("R1 statusAddr", int'(statusAddr), 0);
    rstN = 1;
    step();

    foreach (VECS[i]) begin
      clearSticky();
      e0 = errCnt; d0 = doneCnt; o0 = okCnt;
      fullDuplex = VECS[i].fd; hugeEnable = VECS[i].huge;
      startFrame(VECS[i].len, 13'(100 + i));
      chk("R2 request raised", int'(txRequest), 1);
      chk("R2 statusAddr", int'(statusAddr), 101 + i);
      applied = 0;
      for (int c = 0; c < int'(VECS[i].coll); c++) begin
        collision = 1; bytesSent = VECS[i].bytes;
        step();
        collision = 0;
        applied++;
        if (!txRequest) break;
      end
      chk("R4 collisions applied", applied, int'(VECS[i].coll));
      step();
      if (txRequest) begin
        txEndOk = 1;
        step();
        txEndOk = 0;
      end
      step();
      chk("R8 request low", int'(txRequest), 0);
      chk("R8 err events", errCnt - e0, int'(VECS[i].expAbort));
      chk("R8 abortSticky", int'(abortSticky), int'(VECS[i].expAbort));
      chk("R5 lateColSticky", int'(lateColSticky), int'(VECS[i].expLate));
      chk("R10 done events", doneCnt - d0, 1);
      chk("R10 ok events", okCnt - o0, int'(!VECS[i].expAbort));
    end
    fullDuplex = 0; hugeEnable = 0;

    // R8 no automatic retransmission after last abort state
    clearSticky();
    startFrame(16'd2000, 13'd5);
    repeat (6) step();
    chk("R8 stays idle", int'(txRequest), 0);

    // R10 leftover abort flag suppresses success
    o0 = okCnt; d0 = doneCnt;
    startFrame(16'd100, 13'd6);
    txEndOk = 1; step(); txEndOk = 0; step();
    chk("R10 ok suppressed", okCnt - o0, 0);
    chk("R10 done still", doneCnt - d0, 1);
    chk("R11 sticky survives", int'(abortSticky), 1);

    // R11 clear only on write, set beats clear
    clrAbort = 1; step(); clrAbort = 0;
    chk("R11 cleared", int'(abortSticky), 0);
    startFrame(16'd2000, 13'd7);
    clrAbort = 1; step(); clrAbort = 0;
    chk("R11 set wins", int'(abortSticky), 1);
    clearSticky();

    // R2 start while active ignored; address wrap
    startFrame(16'd100, 13'h1FFF);
    chk("R2 wrap", int'(statusAddr), 0);
    startFrame(16'd100, 13'd40);
    chk("R2 restart ignored", int'(statusAddr), 0);
    chk("R2 still active", int'(txRequest), 1);
    d0 = doneCnt; e0 = errCnt; o0 = okCnt;
    // R9 cancel
    hostCancel = 1; step(); hostCancel = 0; step();
    chk("R9 request low", int'(txRequest), 0);
    chk("R9 done", doneCnt - d0, 1);
    chk("R9 no err", errCnt - e0, 0);
    chk("R9 no ok", okCnt - o0, 0);

    // R12 abort coincides with cancel and end
    e0 = errCnt; o0 = okCnt;
    startFrame(16'd2000, 13'd8);
    hostCancel = 1; txEndOk = 1; step(); hostCancel = 0; txEndOk = 0; step();
    chk("R12 err reported", errCnt - e0, 1);
    chk("R12 no ok", okCnt - o0, 0);
    clearSticky();

    // R6 deferral fires on exact cycle
    e0 = errCnt;
    startFrame(16'd100, 13'd9);
    mediumBusy = 1;
    repeat (DEFER_EXP - 1) step();
    chk("R6 not yet", int'(txRequest), 1);
    step();
    mediumBusy = 0;
    chk("R6 deferral abort", int'(txRequest), 0);
    step();
    chk("R6 err event", errCnt - e0, 1);
    clearSticky();

    // R6 idle cycle restarts the count
    startFrame(16'd100, 13'd10);
    mediumBusy = 1; repeat (2000) step();
    mediumBusy = 0; step();
    mediumBusy = 1; repeat (DEFER_EXP - 1) step();
    mediumBusy = 0;
    chk("R6 restart", int'(txRequest), 1);
    // R6 wait forever
    deferForever = 1; mediumBusy = 1; repeat (DEFER_EXP + 50) step();
    mediumBusy = 0; deferForever = 0;
    chk("R6 defer forever", int'(txRequest), 1);
    txEndOk = 1; step(); txEndOk = 0; step();

    // R7 full duplex ignores carrier
    fullDuplex = 1;
    startFrame(16'd100, 13'd11);
    mediumBusy = 1; repeat (DEFER_EXP + 50) step();
    mediumBusy = 0;
    chk("R7 carrier ignored", int'(txRequest), 1);
    txEndOk = 1; step(); txEndOk = 0; step();
    chk("R7 no abort", int'(abortSticky), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule